// File: doc/BRIEF.md
# Frame Capture and Row Readout Sequencer

This block drives the digital switch controls of a two-dimensional array of per-channel sample-and-hold cells, each cell holding two analog storage slots. On a frame tick it closes the sampling switches of every cell at once, so that the whole frame is taken at one instant. It releases the bottom-plate switch a programmable number of cycles before the main switch, which keeps the charge injected at switch-off independent of the signal. Successive frames go to alternate slots, so the two most recent frames are always held.

After the capture the block walks the rows in order. Each row read begins with a precharge pulse that pulls the shared sampling node to a fixed level. Two phase clocks follow, each separated from the other by a programmable dead time, and their OR is given to the column-parallel differencing stage as its read-out sampling clock. All durations come in on input ports and count clock cycles. A value of zero is treated as one. The configuration has to be chosen so that one full sequence fits within the frame period.

A busy output covers the whole sequence. A frame tick that arrives while busy is dropped and counted.

Top module: `shs_frame_sequencer`

## Requirements
- R1: While reset is asserted and after its release, with no frame tick, every switch, select and phase output is 0, busy is 0, the overrun count is 0 and newer_slot is 1.
- R2: A frame tick sampled while idle raises busy, samp_main and samp_bot at the next clock edge, and samp_bot stays high for max(samp_len,1) cycles.
- R3: samp_bot goes low exactly max(gap_len,1) cycles before samp_main goes low, and samp_bot is never high while samp_main is low.
- R4: Each accepted frame tick toggles newer_slot. While samp_main is high, slot_sel is one-hot with bit i set for slot i, where i is the slot being written, which equals the new newer_slot. At all other times slot_sel is 0.
- R5: After sampling, row_sel selects row 0 (bit 0) up to row ROWS-1 in increasing order. Exactly one bit is set while a row is being read, and no bit is set during sampling or while idle.
- R6: Each row read starts with node_rst high for max(rst_len,1) cycles while row_sel is active and both phases are low.
- R7: In each row, ph1 and then ph2 each go high once for max(ph_len,1) cycles. They are never high together. Before each phase rises there are exactly max(dead_len,1) cycles with both phases and node_rst low. rd_clk equals ph1 OR ph2.
- R8: busy stays high for exactly S+G+ROWS*(R+3D+2P) cycles, where each letter is the matching length clamped to a minimum of 1.
- R9: A frame tick sampled while busy leaves the sequence and newer_slot unchanged, and increments overrun_cnt by 1 at the next edge, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Start-of-frame request, one cycle |
| samp_len | input | CNT_W | Cycles with both sampling switches closed |
| gap_len | input | CNT_W | Cycles between bottom-plate and main switch opening |
| rst_len | input | CNT_W | Precharge pulse length per row |
| dead_len | input | CNT_W | Dead time before each phase |
| ph_len | input | CNT_W | High time of each phase |
| samp_main | output | 1 | Main sampling switch, all cells |
| samp_bot | output | 1 | Bottom-plate switch, all cells |
| slot_sel | output | 2 | One-hot storage slot being written |
| newer_slot | output | 1 | Index of the slot holding the newest frame |
| row_sel | output | ROWS | One-hot row select |
| node_rst | output | 1 | Sampling node precharge pulse |
| ph1 | output | 1 | First read phase |
| ph2 | output | 1 | Second read phase |
| rd_clk | output | 1 | Read-out sampling clock, OR of the phases |
| busy | output | 1 | Sequence in progress |
| overrun_cnt | output | OVR_W | Dropped frame ticks |

## Verification
The bench aims at the clamp of zero-valued lengths. A design that loaded zero unchanged would wrap its counter and make the sequence hundreds of cycles too long. It measures the exact dead time before each phase rise, because an off-by-one there either merges the two phases or shortens the margin. It also checks row order and slot alternation across back-to-back frames, where a design that toggled the slot on a dropped tick, or skipped the last row, would corrupt the difference pairs. A frame tick injected mid-sequence must raise only the overrun count. A reset in mid-frame must return every output to its idle value.

// File: rtl/shs_pkg.sv
package shs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SAMP, ST_GAP, ST_PRE, ST_DA, ST_P1, ST_DB, ST_P2, ST_DC
  } seq_state_t;

  // Length minus one, with zero treated as a length of one
  function automatic logic [7:0] len_m1(input logic [7:0] len);
    return (len == 8'd0) ? 8'd0 : len - 8'd1;
  endfunction
endpackage

// File: rtl/shs_phase_fsm.sv
module shs_phase_fsm
  import shs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             last_row,
  input  logic [CNT_W-1:0] samp_len,
  input  logic [CNT_W-1:0] gap_len,
  input  logic [CNT_W-1:0] rst_len,
  input  logic [CNT_W-1:0] dead_len,
  input  logic [CNT_W-1:0] ph_len,
  output logic             samp_main,
  output logic             samp_bot,
  output logic             node_rst,
  output logic             ph1,
  output logic             ph2,
  output logic             busy,
  output logic             row_load,
  output logic             row_step,
  output logic             row_clr
);
  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [CNT_W-1:0] dm1(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    row_load = 1'b0;
    row_step = 1'b0;
    row_clr  = 1'b0;
    if (st_q == ST_IDLE) begin
      if (start) begin
        st_d  = ST_SAMP;
        cnt_d = dm1(samp_len);
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (st_q)
        ST_SAMP: begin st_d = ST_GAP; cnt_d = dm1(gap_len);  end
        ST_GAP:  begin st_d = ST_PRE; cnt_d = dm1(rst_len); row_load = 1'b1; end
        ST_PRE:  begin st_d = ST_DA;  cnt_d = dm1(dead_len); end
        ST_DA:   begin st_d = ST_P1;  cnt_d = dm1(ph_len);   end
        ST_P1:   begin st_d = ST_DB;  cnt_d = dm1(dead_len); end
        ST_DB:   begin st_d = ST_P2;  cnt_d = dm1(ph_len);   end
        ST_P2:   begin st_d = ST_DC;  cnt_d = dm1(dead_len); end
        ST_DC: begin
          if (last_row) begin
            st_d    = ST_IDLE;
            row_clr = 1'b1;
          end else begin
            st_d     = ST_PRE;
            cnt_d    = dm1(rst_len);
            row_step = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign samp_bot  = (st_q == ST_SAMP);
  assign samp_main = (st_q == ST_SAMP) || (st_q == ST_GAP);
  assign node_rst  = (st_q == ST_PRE);
  assign ph1       = (st_q == ST_P1);
  assign ph2       = (st_q == ST_P2);
  assign busy      = (st_q != ST_IDLE);

  // R3
  main_after_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_main) |-> !$past(samp_bot));
  // R7
  ph2_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph2) |-> !$past(ph1));
  // R2
  start_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (samp_main && samp_bot));
endmodule

// File: rtl/shs_row_ring.sv
module shs_row_ring #(
  parameter int ROWS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_load,
  input  logic            row_step,
  input  logic            row_clr,
  output logic [ROWS-1:0] row_sel,
  output logic            last_row
);
  logic [ROWS-1:0] row_q, row_d;
  logic            row_en;

  assign row_en = row_load | row_step | row_clr;

  always_comb begin
    row_d = row_q;
    if (row_load)      row_d = {{(ROWS-1){1'b0}}, 1'b1};
    else if (row_step) row_d = {row_q[ROWS-2:0], 1'b0};
    else if (row_clr)  row_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  assign row_sel  = row_q;
  assign last_row = row_q[ROWS-1];

  // R5
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));
endmodule

// File: rtl/shs_overrun_ctr.sv
module shs_overrun_ctr #(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  output logic [OVR_W-1:0] count
);
  logic [OVR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = drop && (cnt_q != {OVR_W{1'b1}});
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/shs_frame_sequencer.sv
module shs_frame_sequencer #(
  parameter int ROWS  = 16,
  parameter int CNT_W = 8,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [CNT_W-1:0] samp_len,
  input  logic [CNT_W-1:0] gap_len,
  input  logic [CNT_W-1:0] rst_len,
  input  logic [CNT_W-1:0] dead_len,
  input  logic [CNT_W-1:0] ph_len,
  output logic             samp_main,
  output logic             samp_bot,
  output logic [1:0]       slot_sel,
  output logic             newer_slot,
  output logic [ROWS-1:0]  row_sel,
  output logic             node_rst,
  output logic             ph1,
  output logic             ph2,
  output logic             rd_clk,
  output logic             busy,
  output logic [OVR_W-1:0] overrun_cnt
);
  localparam int SLOTS = 2;

  logic row_load, row_step, row_clr, last_row;
  logic accept, drop;
  logic slot_q, slot_d;

  assign accept = frame_tick && !busy;
  assign drop   = frame_tick && busy;

  shs_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(frame_tick), .last_row(last_row),
    .samp_len(samp_len), .gap_len(gap_len), .rst_len(rst_len),
    .dead_len(dead_len), .ph_len(ph_len),
    .samp_main(samp_main), .samp_bot(samp_bot), .node_rst(node_rst),
    .ph1(ph1), .ph2(ph2), .busy(busy),
    .row_load(row_load), .row_step(row_step), .row_clr(row_clr)
  );

  shs_row_ring #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .row_load(row_load), .row_step(row_step),
    .row_clr(row_clr), .row_sel(row_sel), .last_row(last_row)
  );

  shs_overrun_ctr #(.OVR_W(OVR_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .drop(drop), .count(overrun_cnt)
  );

  assign slot_d = ~slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slot_q <= 1'b1;
    else if (accept) slot_q <= slot_d;
  end

  assign newer_slot = slot_q;
  assign rd_clk     = ph1 | ph2;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_sel[s] = samp_main && (slot_q == s[0]);
  end

  // R4
  slot_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_main) |-> (newer_slot != $past(newer_slot)));
  // R7
  phase_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clk |-> ($onehot(row_sel) && !node_rst));
  // R6
  pre_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_rst |-> $onehot(row_sel));
  // R9
  overrun_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && busy && (overrun_cnt != {OVR_W{1'b1}})) |=>
      (overrun_cnt == $past(overrun_cnt) + 1'b1));
  // R9
  drop_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && busy) |=> $stable(newer_slot));
endmodule

// File: tb/shs_frame_sequencer_tb.sv
module shs_frame_sequencer_tb;
  localparam int ROWS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic [7:0] samp_len = 8'd1, gap_len = 8'd1, rst_len = 8'd1;
  logic [7:0] dead_len = 8'd1, ph_len = 8'd1;
  logic samp_main, samp_bot, newer_slot, node_rst, ph1, ph2, rd_clk, busy;
  logic [1:0] slot_sel;
  logic [ROWS-1:0] row_sel;
  logic [7:0] overrun_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_slot = 1'b1;

  always #10 clk = ~clk;

  shs_frame_sequencer #(.ROWS(ROWS), .CNT_W(8), .OVR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .samp_len(samp_len), .gap_len(gap_len), .rst_len(rst_len),
    .dead_len(dead_len), .ph_len(ph_len),
    .samp_main(samp_main), .samp_bot(samp_bot), .slot_sel(slot_sel),
    .newer_slot(newer_slot), .row_sel(row_sel), .node_rst(node_rst),
    .ph1(ph1), .ph2(ph2), .rd_clk(rd_clk), .busy(busy),
    .overrun_cnt(overrun_cnt)
  );

  // {samp, gap, rst, dead, ph}
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
    {8'd3, 8'd2, 8'd2, 8'd1, 8'd3},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd5, 8'd4, 8'd1, 8'd2, 8'd2},
    {8'd2, 8'd7, 8'd3, 8'd3, 8'd1},
    {8'd4, 8'd1, 8'd2, 8'd1, 8'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cl(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  task automatic check_idle(input string req);
    check(req, int'({samp_main, samp_bot, node_rst, ph1, ph2, rd_clk, busy}), 0);
    check(req, int'(slot_sel), 0);
    check(req, int'(row_sel), 0);
  endtask

  task automatic run_frame(input logic [39:0] v, input int extra_at);
    int s, g, r, d, p, n, bot_n, gap_n, pre_n, rdh_n, rdr_n, ovl_n;
    int rows_seen, row_bad, slot_bad, dead_bad, lowrun, ph1_n, ph2_n;
    logic prev_rd, prev_p1, prev_p2;
    logic [ROWS-1:0] prev_row;
    logic [7:0] ovr0;
    {samp_len, gap_len, rst_len, dead_len, ph_len} = v;
    s = cl(v[39:32]); g = cl(v[31:24]); r = cl(v[23:16]);
    d = cl(v[15:8]);  p = cl(v[7:0]);
    n = 0; bot_n = 0; gap_n = 0; pre_n = 0; rdh_n = 0; rdr_n = 0; ovl_n = 0;
    rows_seen = 0; row_bad = 0; slot_bad = 0; dead_bad = 0; lowrun = 0;
    ph1_n = 0; ph2_n = 0;
    prev_rd = 1'b0; prev_p1 = 1'b0; prev_p2 = 1'b0; prev_row = '0;
    ovr0 = overrun_cnt;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    exp_slot = ~exp_slot;
    while (busy && n < 5000) begin
      if (samp_bot) bot_n++;
      if (samp_main && !samp_bot) gap_n++;
      if (samp_bot && !samp_main) gap_n += 1000;
      if (slot_sel != (samp_main ? (exp_slot ? 2'b10 : 2'b01) : 2'b00)) slot_bad++;
      if (node_rst) begin
        pre_n++;
        if (rd_clk) row_bad++;
      end
      if (rd_clk) rdh_n++;
      if (rd_clk != (ph1 | ph2)) ovl_n++;
      if (ph1 && ph2) ovl_n++;
      if (ph1 && !prev_p1) ph1_n++;
      if (ph2 && !prev_p2) begin
        ph2_n++;
        if (ph1_n != ph2_n) row_bad++;
      end
      if (rd_clk && !prev_rd) begin
        rdr_n++;
        if (lowrun != d) dead_bad++;
      end
      if (!rd_clk && !node_rst && row_sel != '0) lowrun++;
      else lowrun = 0;
      if (samp_main && row_sel != '0) row_bad++;
      if (row_sel != prev_row && row_sel != '0) begin
        if (rows_seen >= ROWS || row_sel != (ROWS'(1) << rows_seen)) row_bad++;
        rows_seen++;
      end
      prev_rd = rd_clk; prev_p1 = ph1; prev_p2 = ph2; prev_row = row_sel;
      n++;
      @(negedge clk);
      frame_tick = (extra_at != 0 && n == extra_at);
    end
    frame_tick = 1'b0;
    check("R8 busy length", n, s + g + ROWS * (r + 3 * d + 2 * p));
    check("R2 both switches closed", bot_n, s);
    check("R3 bottom-plate lead", gap_n, g);
    check("R4 slot select", slot_bad, 0);
    check("R4 newer slot", int'(newer_slot), int'(exp_slot));
    check("R5 rows seen", rows_seen, ROWS);
    check("R5 row order", row_bad, 0);
    check("R6 precharge cycles", pre_n, ROWS * r);
    check("R7 phase high cycles", rdh_n, 2 * ROWS * p);
    check("R7 phase pulses", rdr_n, 2 * ROWS);
    check("R7 dead time", dead_bad, 0);
    check("R7 overlap", ovl_n, 0);
    check("R9 overrun count", int'(overrun_cnt), int'(ovr0) + (extra_at != 0 ? 1 : 0));
    check_idle("R5 idle after frame");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    check("R1 overrun in reset", int'(overrun_cnt), 0);
    check("R1 newer slot in reset", int'(newer_slot), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 after release");

    foreach (VEC[i]) run_frame(VEC[i], 0);

    // R9: tick while busy is dropped and counted
    run_frame(VEC[1], 10);
    run_frame(VEC[0], 60);
    // back-to-back frame right after completion still accepted
    run_frame(VEC[2], 0);

    // mid-frame reset returns to idle (R1)
    {samp_len, gap_len, rst_len, dead_len, ph_len} = VEC[3];
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 mid-frame reset");
    check("R1 overrun after reset", int'(overrun_cnt), 0);
    check("R1 newer slot after reset", int'(newer_slot), 1);
    rst_n = 1'b1;
    exp_slot = 1'b1;
    run_frame(VEC[4], 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule